// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Unit

This block sits inside a serial peripheral and answers for it on a shared interrupt line that is ordered by position in an enable chain. Eight internal event lines from the serial channels are gated by a mask register. When at least one unmasked event is pending, and the device upstream passes the enable, the block pulls an active-low request to the processor. The enable the block passes on to the next device is combinational, so a long chain settles without spending a clock per device.

During an acknowledge cycle the highest enabled device with a pending event claims the cycle. It drops its downstream enable and, while the read strobe is also low, drives the contents of a programmable vector register onto the data bus under a separate output enable. The output enable controls the pad tri-state. When the read strobe falls, the device marks itself in service. It then releases its request and keeps every lower device blocked until software writes the end-of-service command.

Configuration uses one write port with a two-bit select. Select 0 loads the vector, select 1 loads the mask, and select 2 is the end-of-service command, which ignores its data. Select 3 has no effect.

Top module: `ivu_daisy`

## Requirements
- R1: After a synchronous active-high reset the vector is 0x0F, the mask is all zeros, nothing is in service, `irq_n` is high and `vec_oe` is low, even with every source pending.
- R2: `irq_n` is low exactly when `chain_in` is high, `src_pend & mask` is non-zero, and nothing is in service.
- R3: `chain_out` is high only when `chain_in` is high, nothing is in service, and it is not the case that `ack_n` is low with a masked source pending. While in service, `chain_out` stays low whatever the strobes do.
- R4: `vec_oe` is high only while `ack_n` and `rd_n` are both low and this device has claimed the cycle. While `vec_oe` is high, `vec_data` equals the vector register; otherwise `vec_data` is 0.
- R5: At the first clock edge where `rd_n` is sampled low after being high, during a claimed acknowledge, the device enters service. From that edge `irq_n` is high, and the vector stays driven until `ack_n` or `rd_n` rises.
- R6: A write with `cfg_sel` = 2 ends service at that clock edge, after which `chain_out` and `irq_n` follow R2 and R3 again.
- R7: A write with `cfg_sel` = 0 loads `cfg_wdata` into the vector register. A write with `cfg_sel` = 1 loads it into the mask register, with bit i gating `src_pend[i]`. Both take effect from the clock edge of the write.
- R8: If an end-of-service write and a read-strobe fall that enters service occur at the same edge, the device ends that edge in service.
- R9: A read-strobe fall during an acknowledge that this device has not claimed (because `chain_in` is low or nothing is pending) does not put it in service.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_pend | input | 8 | Pending event lines from the serial channels |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 vector, 1 mask, 2 end-of-service, 3 no effect |
| cfg_wdata | input | 8 | Configuration write data |
| chain_in | input | 1 | Enable from the higher-priority neighbour |
| chain_out | output | 1 | Enable to the lower-priority neighbour |
| ack_n | input | 1 | Interrupt acknowledge, active low |
| rd_n | input | 1 | Read strobe, active low |
| irq_n | output | 1 | Interrupt request, active low |
| vec_data | output | 8 | Vector bus data |
| vec_oe | output | 1 | Output enable for the vector bus pads |

## Verification
Two functions can fall in the same cycle: entering service on a read-strobe fall, and software ending service through the command write. The bench lowers `rd_n` during a claimed acknowledge and issues the end-of-service write so that both are sampled at the same edge. It then expects `irq_n` released and `chain_out` held low after the strobes return high, which shows that the set won. A separate sequence lowers the read strobe while the chain is disabled and confirms that the device stays out of service.

// File: rtl/ivu_pkg.sv
package ivu_pkg;
  typedef enum logic [1:0] {
    SEL_VECTOR  = 2'd0,
    SEL_MASK    = 2'd1,
    SEL_END_SVC = 2'd2,
    SEL_NONE    = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/ivu_regs.sv
module ivu_regs #(
  parameter int NSRC = 8,
  parameter int VW   = 8,
  parameter logic [VW-1:0] VEC_INIT = 8'h0F
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [VW-1:0]   cfg_wdata,
  output logic [VW-1:0]   vec_q,
  output logic [NSRC-1:0] mask_q,
  output logic            end_svc_ev
);
  import ivu_pkg::*;

  logic wr_vec, wr_mask;
  assign wr_vec     = cfg_we && (cfg_sel == SEL_VECTOR);
  assign wr_mask    = cfg_we && (cfg_sel == SEL_MASK);
  assign end_svc_ev = cfg_we && (cfg_sel == SEL_END_SVC);

  always_ff @(posedge clk) begin
    if (rst)         vec_q <= VEC_INIT;
    else if (wr_vec) vec_q <= cfg_wdata;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_mask
    always_ff @(posedge clk) begin
      if (rst)          mask_q[i] <= 1'b0;
      else if (wr_mask) mask_q[i] <= cfg_wdata[i];
    end
  end
endmodule

// File: rtl/ivu_service.sv
module ivu_service (
  input  logic clk,
  input  logic rst,
  input  logic rd_n,
  input  logic ack_n,
  input  logic claim,
  input  logic end_svc_ev,
  output logic ius_q,
  output logic serving_q,
  output logic enter_ev
);
  logic rd_prev_q;

  assign enter_ev = claim && rd_prev_q && !rd_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_prev_q <= 1'b1;
      ius_q     <= 1'b0;
      serving_q <= 1'b0;
    end else begin
      rd_prev_q <= rd_n;
      if (enter_ev)        ius_q <= 1'b1;
      else if (end_svc_ev) ius_q <= 1'b0;
      if (enter_ev)        serving_q <= 1'b1;
      else if (ack_n)      serving_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ivu_chain.sv
module ivu_chain #(
  parameter int NSRC = 8,
  parameter int VW   = 8
) (
  input  logic            chain_in,
  input  logic            ack_n,
  input  logic            rd_n,
  input  logic [NSRC-1:0] src_pend,
  input  logic [NSRC-1:0] mask_q,
  input  logic            ius_q,
  input  logic            serving_q,
  input  logic [VW-1:0]   vec_q,
  output logic            armed,
  output logic            claim,
  output logic            irq_n,
  output logic            chain_out,
  output logic            vec_oe,
  output logic [VW-1:0]   vec_data
);
  function automatic logic any_enabled(input logic [NSRC-1:0] s, input logic [NSRC-1:0] m);
    return |(s & m);
  endfunction

  function automatic logic pass_enable(input logic in_en, input logic svc,
                                       input logic ack_lo, input logic pend);
    return in_en && !svc && !(ack_lo && pend);
  endfunction

  assign armed     = any_enabled(src_pend, mask_q);
  assign claim     = !ack_n && chain_in && armed && !ius_q;
  assign irq_n     = !(chain_in && armed && !ius_q);
  assign chain_out = pass_enable(chain_in, ius_q, !ack_n, armed);
  assign vec_oe    = !ack_n && !rd_n && chain_in && (claim || serving_q);
  assign vec_data  = vec_oe ? vec_q : '0;
endmodule

// File: rtl/ivu_daisy.sv
module ivu_daisy #(
  parameter int NSRC = 8,
  parameter int VW   = 8,
  parameter logic [VW-1:0] VEC_INIT = 8'h0F
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_pend,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [VW-1:0]   cfg_wdata,
  input  logic            chain_in,
  output logic            chain_out,
  input  logic            ack_n,
  input  logic            rd_n,
  output logic            irq_n,
  output logic [VW-1:0]   vec_data,
  output logic            vec_oe
);
  logic [VW-1:0]   vec_q;
  logic [NSRC-1:0] mask_q;
  logic            end_svc_ev, enter_ev, ius_q, serving_q, armed, claim;

  ivu_regs #(.NSRC(NSRC), .VW(VW), .VEC_INIT(VEC_INIT)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .vec_q(vec_q), .mask_q(mask_q), .end_svc_ev(end_svc_ev)
  );

  ivu_service u_svc (
    .clk(clk), .rst(rst), .rd_n(rd_n), .ack_n(ack_n), .claim(claim),
    .end_svc_ev(end_svc_ev), .ius_q(ius_q), .serving_q(serving_q), .enter_ev(enter_ev)
  );

  ivu_chain #(.NSRC(NSRC), .VW(VW)) u_chain (
    .chain_in(chain_in), .ack_n(ack_n), .rd_n(rd_n), .src_pend(src_pend),
    .mask_q(mask_q), .ius_q(ius_q), .serving_q(serving_q), .vec_q(vec_q),
    .armed(armed), .claim(claim), .irq_n(irq_n), .chain_out(chain_out),
    .vec_oe(vec_oe), .vec_data(vec_data)
  );
endmodule

// File: rtl/ivu_daisy_chk.sv
module ivu_daisy_chk #(
  parameter int VW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          chain_in,
  input logic          chain_out,
  input logic          ack_n,
  input logic          rd_n,
  input logic          irq_n,
  input logic          vec_oe,
  input logic [VW-1:0] vec_data,
  input logic          ius_q,
  input logic          enter_ev,
  input logic          end_svc_ev
);
  AST_RESET_QUIET:   assert property (@(posedge clk) disable iff (rst) $past(rst) |-> irq_n && !vec_oe); // R1
  AST_IRQ_NEEDS_EN:  assert property (@(posedge clk) disable iff (rst) !irq_n |-> chain_in && !ius_q); // R2
  AST_OUT_NEEDS_IN:  assert property (@(posedge clk) disable iff (rst) chain_out |-> chain_in && !ius_q); // R3
  AST_OE_BLOCKS_OUT: assert property (@(posedge clk) disable iff (rst) vec_oe |-> !chain_out); // R3
  AST_OE_STROBES:    assert property (@(posedge clk) disable iff (rst) vec_oe |-> !ack_n && !rd_n); // R4
  AST_BUS_QUIET:     assert property (@(posedge clk) disable iff (rst) !vec_oe |-> vec_data == '0); // R4
  AST_ENTER_SVC:     assert property (@(posedge clk) disable iff (rst) enter_ev |=> ius_q && irq_n); // R5
  AST_END_SVC:       assert property (@(posedge clk) disable iff (rst) end_svc_ev && !enter_ev |=> !ius_q); // R6
endmodule

bind ivu_daisy ivu_daisy_chk #(.VW(VW)) u_chk (
  .clk(clk), .rst(rst), .chain_in(chain_in), .chain_out(chain_out), .ack_n(ack_n),
  .rd_n(rd_n), .irq_n(irq_n), .vec_oe(vec_oe), .vec_data(vec_data), .ius_q(ius_q),
  .enter_ev(enter_ev), .end_svc_ev(end_svc_ev)
);

// File: tb/test_ivu_daisy.sv
`timescale 1ns/1ps
module test_ivu_daisy;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] src_pend = '0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd3;
  logic [7:0] cfg_wdata = '0;
  logic       chain_in = 1'b1;
  logic       ack_n = 1'b1;
  logic       rd_n = 1'b1;
  logic       chain_out, irq_n, vec_oe;
  logic [7:0] vec_data;
  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] cur_vec = 8'h0F;

  always #4 clk = ~clk;

  ivu_daisy i_ivu_daisy (
    .clk(clk), .rst(rst), .src_pend(src_pend), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .chain_in(chain_in), .chain_out(chain_out), .ack_n(ack_n),
    .rd_n(rd_n), .irq_n(irq_n), .vec_data(vec_data), .vec_oe(vec_oe)
  );

  // row: mask, src, chain_in, ack_n, rd_n, exp irq_n, exp chain_out, exp vec_oe
  localparam logic [21:0] TBL [8] = '{
    {8'hFF, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
    {8'hFF, 8'h04, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {8'h0F, 8'hF0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
    {8'h0F, 8'h08, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'h0F, 8'h08, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'h0F, 8'h08, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    {8'h0F, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    {8'h80, 8'h80, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}
  };

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [7:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #2;
    cfg_we = 1'b0; cfg_sel = 2'd3;
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    src_pend = 8'hFF;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1: reset state, all sources pending but masked off
    check("R1", "irq_n", {7'd0, irq_n}, 8'd1);
    check("R1", "chain_out", {7'd0, chain_out}, 8'd1);
    check("R1", "vec_oe", {7'd0, vec_oe}, 8'd0);
    ack_n = 1'b0; rd_n = 1'b0; #1;
    check("R1", "vec_oe under strobes", {7'd0, vec_oe}, 8'd0);
    check("R1", "vec_data", vec_data, 8'h00);
    ack_n = 1'b1; rd_n = 1'b1;
    tick();

    // table walk: R2 R3 R4 R7 combinational behaviour, reset vector 0x0F
    for (int i = 0; i < 8; i++) begin
      cfg_write(2'd1, TBL[i][21:14]);
      src_pend = TBL[i][13:6]; chain_in = TBL[i][5]; ack_n = TBL[i][4]; rd_n = TBL[i][3];
      #1;
      check("R2", $sformatf("row%0d irq_n", i), {7'd0, irq_n}, {7'd0, TBL[i][2]});
      check("R3", $sformatf("row%0d chain_out", i), {7'd0, chain_out}, {7'd0, TBL[i][1]});
      check("R4", $sformatf("row%0d vec_oe", i), {7'd0, vec_oe}, {7'd0, TBL[i][0]});
      check("R4", $sformatf("row%0d vec_data", i), vec_data, TBL[i][0] ? cur_vec : 8'h00);
      ack_n = 1'b1; rd_n = 1'b1; chain_in = 1'b1;
      tick();
    end

    // R7: program vector and mask
    cfg_write(2'd0, 8'hA5); cur_vec = 8'hA5;
    cfg_write(2'd1, 8'h01);
    src_pend = 8'h02; #1;
    check("R7", "mask bit1 off", {7'd0, irq_n}, 8'd1);
    src_pend = 8'h01; #1;
    check("R7", "mask bit0 on", {7'd0, irq_n}, 8'd0);

    // R4/R5: claimed acknowledge and read
    ack_n = 1'b0; tick();
    rd_n = 1'b0; #1;
    check("R4", "vector driven", vec_data, 8'hA5);
    tick();
    check("R5", "irq released", {7'd0, irq_n}, 8'd1);
    check("R5", "vector held", vec_data, 8'hA5);
    check("R5", "chain_out low", {7'd0, chain_out}, 8'd0);
    rd_n = 1'b1; ack_n = 1'b1; tick();
    check("R3", "in service blocks", {7'd0, chain_out}, 8'd0);
    check("R5", "no vector after", {7'd0, vec_oe}, 8'd0);
    check("R5", "irq stays high", {7'd0, irq_n}, 8'd1);

    // R6: end of service
    cfg_write(2'd2, 8'h00);
    check("R6", "chain_out back", {7'd0, chain_out}, 8'd1);
    check("R6", "irq back", {7'd0, irq_n}, 8'd0);

    // R9: unclaimed read fall
    chain_in = 1'b0; ack_n = 1'b0; tick();
    rd_n = 1'b0; tick(); tick();
    rd_n = 1'b1; ack_n = 1'b1; chain_in = 1'b1; tick();
    check("R9", "not in service chain_out", {7'd0, chain_out}, 8'd1);
    check("R9", "not in service irq", {7'd0, irq_n}, 8'd0);

    // R8: end-of-service write coinciding with entering service
    ack_n = 1'b0; tick();
    rd_n = 1'b0;
    cfg_write(2'd2, 8'h00);
    check("R8", "irq released", {7'd0, irq_n}, 8'd1);
    rd_n = 1'b1; ack_n = 1'b1; tick();
    check("R8", "still in service", {7'd0, chain_out}, 8'd0);
    cfg_write(2'd3, 8'hFF);
    check("R6", "select 3 no effect", {7'd0, chain_out}, 8'd0);
    cfg_write(2'd2, 8'h00);
    check("R6", "final release", {7'd0, chain_out}, 8'd1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule